// File: doc/BRIEF.md
# Watchdog Frequency Fallback Controller

This block supervises a programmable clock synthesizer after its output frequency has been raised. Once software enables it, a down-counter is loaded from a timeout value. A slow periodic tick, one pulse per 290 ms timeout unit, decrements the counter. Software re-arms the counter by kicking it. If the count runs out before a kick arrives, the block latches an alarm status and overrides the active frequency selection with a stored safe code. The override also sends the selection back to the code-based path.

The block also drives an active-low system reset pulse for the rest of the board. The pulse is issued on watchdog expiry and on every change of the effective frequency selection, whether that change is requested by software or forced by the alarm. The pulse length is a fixed number of reference clock cycles. A new trigger restarts it.

The timeout value, enable bit, safe code, requested code, source-select bit and alarm-clear strobe come from a register interface outside the block. The tick is generated outside the block from the reference clock.

Top module: `wdog_freq_guard`

## Requirements
- R1: After reset, `alarm` is 0 and `sys_rst_n` is 1. The effective selection passes the requested code and source bit through unchanged.
- R2: The countdown is loaded from `cfg_timeout` in three cases: on the cycle where `cfg_wd_en` is first seen high, on `kick` while enabled, and on `alarm_clr` while enabled. Each `tick` while enabled and not in alarm lowers the count by one.
- R3: With a timeout of N ≥ 1 units, the N-th tick after loading sets `alarm` on the next clock edge. A timeout of 0 expires on the first tick.
- R4: `alarm` stays 1 until `alarm_clr` is pulsed or `cfg_wd_en` goes to 0. While `alarm` is 1, ticks and kicks do not clear it.
- R5: While `alarm` is 1, `act_code` equals `cfg_safe_code` and `act_src_direct` is 0. Otherwise they equal `cfg_sel_code` and `cfg_src_direct`.
- R6: While `cfg_wd_en` is 0, kicks and ticks have no effect: `alarm` stays 0 and no expiry reset pulse is produced.
- R7: On an expiry, or on a change of {`act_code`, `act_src_direct`} between consecutive cycles, `sys_rst_n` is 0 from the next cycle for PULSE_LEN cycles. A trigger that arrives during a pulse restarts the full length.
- R8: The first cycle after reset is never treated as a selection change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_timeout | input | TMO_W | Timeout in 290 ms units |
| cfg_wd_en | input | 1 | Watchdog enable, 1 = on |
| cfg_safe_code | input | 5 | Fallback frequency code |
| cfg_sel_code | input | 5 | Requested frequency code |
| cfg_src_direct | input | 1 | Requested source: 1 = direct divider registers, 0 = code table |
| alarm_clr | input | 1 | One-cycle strobe that clears the alarm and re-arms the counter |
| tick | input | 1 | One-cycle pulse per timeout unit |
| kick | input | 1 | One-cycle re-arm strobe |
| alarm | output | 1 | Alarm status, 1 = watchdog expired |
| act_code | output | 5 | Effective frequency code |
| act_src_direct | output | 1 | Effective source select |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
The bench builds the block with an 8-bit timeout and PULSE_LEN of 4. Each reset pulse therefore lasts only a few cycles, so the bench can count every pulse cycle exactly and can place a second trigger inside a running pulse. Timeouts of 0 to 3 units bring the boundary expiry, a kick arriving just before expiry, and a clear or disable during alarm within a few dozen cycles. The tick is driven directly, so the 290 ms unit costs one cycle.

// File: rtl/wdg_pkg.sv
// Shared types for the watchdog frequency fallback controller.
// Assumes a 5-bit frequency code plus one source-select bit form a selection.
package wdg_pkg;
    localparam int CODE_W = 5;

    typedef logic [CODE_W-1:0] fcode_t;

    // Effective frequency selection: table code and source select.
    typedef struct packed {
        fcode_t code;
        logic   direct;
    } fsel_t;
endpackage

// File: rtl/wdg_countdown.sv
// Timeout down-counter. It is loaded on enable rise, on a kick or on an alarm
// clear (all only while enabled). It decrements on each tick while not in alarm.
// It produces a one-cycle expire strobe on the tick that finds the count at 1 or 0.
// Assumes tick, kick and clr are single-cycle strobes in the clk domain.
module wdg_countdown #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             kick,
    input  logic             clr,
    input  logic             tick,
    input  logic             alarm,
    input  logic [TMO_W-1:0] timeout,
    output logic             expire
);
    localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

    logic [TMO_W-1:0] cnt;
    logic             en_q;
    logic             load;

    // Load request: new enable, or re-arm while enabled.
    always_comb begin
        load = en & (~en_q | kick | clr);
    end

    // Expiry when the last unit elapses; a load in the same cycle wins.
    always_comb begin
        expire = en & ~load & tick & ~alarm & (cnt <= ONE);
    end

    // Remember the enable level to detect its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en;
    end

    // Countdown register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= timeout;
        end else if (tick && !alarm && cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    // R2: a kick while enabled reloads the count from the timeout value.
    p_kick_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && kick) |=> (cnt == $past(timeout)));

    // R2: without a tick or a load the count does not move.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && en_q && !kick && !clr && !tick) |=> $stable(cnt));

    // R6: a disabled watchdog never expires.
    p_no_expire_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !expire);
endmodule

// File: rtl/wdg_fallback_sel.sv
// Alarm status latch and selection override. The alarm sets on expiry and
// clears on a software clear or when the watchdog is disabled. While the alarm
// is set, the safe code replaces the requested code and the source select is
// forced to the code table. Assumes expire and clr never coincide.
module wdg_fallback_sel
    import wdg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  logic   clr,
    input  logic   expire,
    input  fcode_t safe_code,
    input  fsel_t  req_sel,
    output logic   alarm,
    output fsel_t  act_sel
);
    // Sticky alarm status.
    always_ff @(posedge clk) begin
        if (!rst_n)      alarm <= 1'b0;
        else if (!en)    alarm <= 1'b0;
        else if (clr)    alarm <= 1'b0;
        else if (expire) alarm <= 1'b1;
    end

    // Effective selection: fallback while in alarm.
    always_comb begin
        if (alarm) begin
            act_sel.code   = safe_code;
            act_sel.direct = 1'b0;
        end else begin
            act_sel = req_sel;
        end
    end

    // R3: an expiry strobe from the counter sets the alarm on the next edge.
    p_expire_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> alarm);

    // R4: the alarm holds while enabled and not cleared.
    p_alarm_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && en && !clr) |=> alarm);

    // R6: disabling drops the alarm.
    p_off_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !alarm);
endmodule

// File: rtl/wdg_rst_pulse.sv
// System reset pulse generator. It triggers on expiry or on any change of the
// effective selection between consecutive cycles. It holds the active-low
// output for PULSE_LEN cycles and restarts on a new trigger. The first cycle
// after reset has no previous selection and is never a change.
module wdg_rst_pulse
    import wdg_pkg::*;
#(
    parameter int PULSE_LEN = 32
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  expire,
    input  fsel_t act_sel,
    output logic  sys_rst_n
);
    localparam int              PCW   = $clog2(PULSE_LEN + 1);
    localparam logic [PCW-1:0]  PLOAD = PCW'(PULSE_LEN);
    localparam logic [PCW-1:0]  PONE  = PCW'(1);

    fsel_t          prev_sel;
    logic           prev_vld;
    logic           change;
    logic           trig;
    logic [PCW-1:0] pcnt;

    // Selection change against last cycle, once a previous value exists.
    always_comb begin
        change = prev_vld & (act_sel != prev_sel);
        trig   = expire | change;
    end

    // Track the previous effective selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sel <= '0;
            prev_vld <= 1'b0;
        end else begin
            prev_sel <= act_sel;
            prev_vld <= 1'b1;
        end
    end

    // Pulse length counter; a trigger restarts the full length.
    always_ff @(posedge clk) begin
        if (!rst_n)          pcnt <= '0;
        else if (trig)       pcnt <= PLOAD;
        else if (pcnt != '0) pcnt <= pcnt - PONE;
    end

    // Output is low while the pulse counter runs.
    always_comb begin
        sys_rst_n = (pcnt == '0);
    end

    // R7: any trigger drives the reset low on the next cycle.
    p_pulse_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !sys_rst_n);

    // R7: with no trigger, an idle output stays released.
    p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_n && !trig) |=> sys_rst_n);
endmodule

// File: rtl/wdog_freq_guard.sv
// Watchdog frequency fallback controller top. It connects the countdown, the
// alarm and override latch, and the reset pulse generator. Assumes all inputs
// are synchronous to clk and that tick is one cycle per 290 ms unit.
module wdog_freq_guard
    import wdg_pkg::*;
#(
    parameter int TMO_W     = 8,
    parameter int PULSE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMO_W-1:0]  cfg_timeout,
    input  logic              cfg_wd_en,
    input  logic [CODE_W-1:0] cfg_safe_code,
    input  logic [CODE_W-1:0] cfg_sel_code,
    input  logic              cfg_src_direct,
    input  logic              alarm_clr,
    input  logic              tick,
    input  logic              kick,
    output logic              alarm,
    output logic [CODE_W-1:0] act_code,
    output logic              act_src_direct,
    output logic              sys_rst_n
);
    logic  expire;
    fsel_t req_sel;
    fsel_t act_sel;

    // Pack the requested selection.
    always_comb begin
        req_sel.code   = cfg_sel_code;
        req_sel.direct = cfg_src_direct;
    end

    wdg_countdown #(.TMO_W(TMO_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (cfg_wd_en),
        .kick    (kick),
        .clr     (alarm_clr),
        .tick    (tick),
        .alarm   (alarm),
        .timeout (cfg_timeout),
        .expire  (expire)
    );

    wdg_fallback_sel u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_wd_en),
        .clr       (alarm_clr),
        .expire    (expire),
        .safe_code (cfg_safe_code),
        .req_sel   (req_sel),
        .alarm     (alarm),
        .act_sel   (act_sel)
    );

    wdg_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (expire),
        .act_sel   (act_sel),
        .sys_rst_n (sys_rst_n)
    );

    // Unpack the effective selection.
    always_comb begin
        act_code       = act_sel.code;
        act_src_direct = act_sel.direct;
    end

    // R5: in alarm the source select is back on the code table.
    p_alarm_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> !act_src_direct);
endmodule

// File: tb/wdog_freq_guard_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference model stepped alongside the DUT and compared
// on every cycle, plus directed checks on timing and boundary cases.
module wdog_freq_guard_tb_top;
    localparam int TMO_W = 8;
    localparam int PLEN  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [TMO_W-1:0] cfg_timeout = '0;
    logic             cfg_wd_en = 1'b0;
    logic [4:0]       cfg_safe_code = 5'd0;
    logic [4:0]       cfg_sel_code = 5'd0;
    logic             cfg_src_direct = 1'b0;
    logic             alarm_clr = 1'b0;
    logic             tick = 1'b0;
    logic             kick = 1'b0;
    logic             alarm;
    logic [4:0]       act_code;
    logic             act_src_direct;
    logic             sys_rst_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Reference model state.
    int m_cnt, m_pcnt, m_prev_code;
    bit m_en_q, m_alarm, m_prev_src, m_valid;

    always #4 clk = ~clk;

    wdog_freq_guard #(.TMO_W(TMO_W), .PULSE_LEN(PLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout),
        .cfg_wd_en(cfg_wd_en), .cfg_safe_code(cfg_safe_code),
        .cfg_sel_code(cfg_sel_code), .cfg_src_direct(cfg_src_direct),
        .alarm_clr(alarm_clr), .tick(tick), .kick(kick), .alarm(alarm),
        .act_code(act_code), .act_src_direct(act_src_direct),
        .sys_rst_n(sys_rst_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic int m_code();
        return m_alarm ? int'(cfg_safe_code) : int'(cfg_sel_code);
    endfunction

    function automatic bit m_src();
        return m_alarm ? 1'b0 : cfg_src_direct;
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_pcnt = 0; m_prev_code = 0;
        m_en_q = 0; m_alarm = 0; m_prev_src = 0; m_valid = 0;
    endtask

    // One clock edge of the reference model with the inputs now applied.
    task automatic model_step();
        bit ld, exp_s, chg;
        int nc, na;
        ld    = cfg_wd_en && (!m_en_q || kick || alarm_clr);
        exp_s = cfg_wd_en && !ld && tick && !m_alarm && (m_cnt <= 1);
        chg   = m_valid && ((m_code() != m_prev_code) || (m_src() != m_prev_src));
        if (!cfg_wd_en) nc = 0;
        else if (ld) nc = int'(cfg_timeout);
        else if (tick && !m_alarm && m_cnt > 0) nc = m_cnt - 1;
        else nc = m_cnt;
        if (!cfg_wd_en) na = 0;
        else if (alarm_clr) na = 0;
        else if (exp_s) na = 1;
        else na = int'(m_alarm);
        if (exp_s || chg) m_pcnt = PLEN;
        else if (m_pcnt > 0) m_pcnt = m_pcnt - 1;
        m_prev_code = m_code();
        m_prev_src  = m_src();
        m_valid = 1;
        m_en_q  = cfg_wd_en;
        m_cnt   = nc;
        m_alarm = na[0];
    endtask

    // Per-cycle comparison against the model.
    task automatic compare();
        check(alarm == m_alarm, "R4 alarm vs model", int'(alarm), int'(m_alarm));
        check(int'(act_code) == m_code(), "R5 act_code vs model", int'(act_code), m_code());
        check(act_src_direct == m_src(), "R5 act_src vs model", int'(act_src_direct), int'(m_src()));
        check(sys_rst_n == (m_pcnt == 0), "R7 sys_rst_n vs model", int'(sys_rst_n), int'(m_pcnt == 0));
    endtask

    // Advance one cycle: model step, edge, compare, drop strobes.
    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        kick = 1'b0; tick = 1'b0; alarm_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic do_tick();
        tick = 1'b1; cyc();
    endtask

    task automatic count_low(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            cyc();
            if (!sys_rst_n) lows++;
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lows;
        model_reset();
        cfg_safe_code = 5'd2; cfg_sel_code = 5'd9; cfg_src_direct = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        check(alarm == 1'b0, "R1 alarm after reset", int'(alarm), 0);
        check(sys_rst_n == 1'b1, "R1 sys_rst_n after reset", int'(sys_rst_n), 1);
        check(act_code == 5'd9, "R1 code passes through", int'(act_code), 9);
        // R8: first cycle after reset is not a change.
        cyc();
        check(sys_rst_n == 1'b1, "R8 no pulse after reset", int'(sys_rst_n), 1);

        // R6: disabled, kicks and ticks do nothing.
        cfg_timeout = 8'd0;
        kick = 1'b1; cyc();
        for (int i = 0; i < 5; i++) do_tick();
        check(alarm == 1'b0, "R6 no alarm while disabled", int'(alarm), 0);
        check(sys_rst_n == 1'b1, "R6 no pulse while disabled", int'(sys_rst_n), 1);

        // R3: timeout 3, alarm after third tick.
        cfg_timeout = 8'd3; cfg_wd_en = 1'b1; cyc();
        do_tick(); do_tick();
        check(alarm == 1'b0, "R3 no alarm after two ticks", int'(alarm), 0);
        do_tick();
        check(alarm == 1'b1, "R3 alarm after third tick", int'(alarm), 1);
        check(act_code == 5'd2, "R5 safe code in alarm", int'(act_code), 2);
        check(sys_rst_n == 1'b0, "R7 pulse on expiry", int'(sys_rst_n), 0);
        // R4: ticks and kicks keep the alarm.
        do_tick(); kick = 1'b1; cyc(); idle(6);
        check(alarm == 1'b1, "R4 alarm sticky", int'(alarm), 1);

        // R4/R2: clear re-arms; kicks hold off expiry.
        alarm_clr = 1'b1; cyc();
        check(alarm == 1'b0, "R4 clear drops alarm", int'(alarm), 0);
        idle(6);
        do_tick(); do_tick(); kick = 1'b1; cyc();
        do_tick(); do_tick();
        check(alarm == 1'b0, "R2 kick reloaded count", int'(alarm), 0);
        do_tick();
        check(alarm == 1'b1, "R2 expiry three ticks after kick", int'(alarm), 1);
        idle(6);

        // R4/R6: disable drops alarm.
        cfg_wd_en = 1'b0; cyc();
        check(alarm == 1'b0, "R6 disable clears alarm", int'(alarm), 0);
        idle(6);

        // R3: timeout 0 expires on first tick.
        cfg_timeout = 8'd0; cfg_wd_en = 1'b1; cyc();
        do_tick();
        check(alarm == 1'b1, "R3 zero timeout expires first tick", int'(alarm), 1);
        cfg_wd_en = 1'b0; idle(8);

        // R7: requested code change gives a pulse of exactly PLEN cycles.
        cfg_sel_code = 5'd17;
        count_low(8, lows);
        check(lows == PLEN, "R7 pulse length on code change", lows, PLEN);
        // R5: source bit passes through, and its change also pulses.
        cfg_src_direct = 1'b1;
        cyc();
        check(act_src_direct == 1'b1, "R5 source passes through", int'(act_src_direct), 1);
        check(sys_rst_n == 1'b0, "R7 pulse on source change", int'(sys_rst_n), 0);
        idle(2);
        // R7: retrigger inside a pulse restarts the full length.
        cfg_sel_code = 5'd3;
        count_low(8, lows);
        check(lows == PLEN, "R7 retrigger restarts pulse", lows, PLEN);

        // R5: alarm forces source to code table.
        cfg_timeout = 8'd1; cfg_wd_en = 1'b1; cyc();
        do_tick();
        check(act_src_direct == 1'b0, "R5 alarm forces code source", int'(act_src_direct), 0);
        idle(8);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule